// File: doc/BRIEF.md
# Two-Stage Interrupt Request Latch

This block turns six interrupt request lines into a pending-request register for a processor's interrupt controller. Each line is edge-captured: a rising edge sets a first-stage catch bit that holds its value across any number of cycles. The core raises a sample strobe in the last cycle before an opcode fetch, and that strobe moves every caught edge into the second-stage request register. The mask and priority logic read that register, and software can also read and write it directly.

Levels 0 to 2 come from pins outside the chip. Each passes through a two-flop synchronizer, so for a given sample point these lines must rise two clocks earlier than internal ones. Level 3 is the serial receiver's byte-complete flag. Level 4 is one of two sources, chosen by a select input: timer 0 end-of-count or transmitter-empty. Level 5 is timer 1 end-of-count. When an interrupt is taken, the acknowledge clears only the winning level's bit. A software write replaces the register. If a write and a sample fall in the same cycle, the written value is ORed with the bits being sampled.

Top module: `irq_edge_latch`

## Requirements
- R1: After reset the request register reads 0 and no edge is pending, so a sample strobe with no new edges leaves it at 0.
- R2: A rising edge on an internal source sets its bit after the next sample strobe: bit 3 for rxDone, bit 4 for the selected level-4 source, bit 5 for t1End. If the edge is seen at clock edge k, a strobe at clock edge k+1 captures it.
- R3: A caught edge is held through any number of cycles without a strobe. The strobe empties the catch bit, so a second strobe with no new edge adds nothing.
- R4: An external line that rises before clock edge k is not captured by a strobe at clock edge k+2. It is captured by a strobe at clock edge k+3, which sets bit n for line n.
- R5: When lvl4SelTx is 0, level 4 follows t0End and txEmpty is ignored. When lvl4SelTx is 1, level 4 follows txEmpty and t0End is ignored.
- R6: A sample ORs the caught bits into the register and keeps the bits already pending.
- R7: An acknowledge with ackLevel below 6 clears only that bit. An ackLevel of 6 or 7 clears nothing.
- R8: A write replaces the register with regWrData and takes precedence over an acknowledge in the same cycle. A write in a sample cycle yields regWrData ORed with the sampled bits.
- R9: With no sample, write or acknowledge, the register holds its value.
- R10: A rising edge that arrives in the same cycle as a sample strobe stays caught for the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| extReq | input | 3 | External request lines, levels 0 to 2, asynchronous |
| rxDone | input | 1 | Receiver byte-complete, level 3 |
| t0End | input | 1 | Timer 0 end-of-count, level 4 candidate |
| txEmpty | input | 1 | Transmitter empty, level 4 candidate |
| lvl4SelTx | input | 1 | Level 4 source select: 1 picks txEmpty, 0 picks t0End |
| t1End | input | 1 | Timer 1 end-of-count, level 5 |
| sampleStb | input | 1 | Sample strobe, high in the cycle before an opcode fetch |
| ackValid | input | 1 | Interrupt acknowledge pulse |
| ackLevel | input | 3 | Level being acknowledged |
| regWrEn | input | 1 | Software write strobe for the request register |
| regWrData | input | 6 | Software write data |
| reqReg | output | 6 | Second-stage request register, for priority logic and software read |

## Verification
Any fault in the catch bits only becomes visible after a strobe moves it into reqReg. The sweeps therefore follow every edge with a strobe and then read the port. A lost or stuck catch bit shows as a missing or extra bit one cycle after the next strobe. A wrong synchronizer depth shows as a one-cycle shift in which strobe first captures an external line. A wrong acknowledge decode or write priority shows in reqReg on the very next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // One-cycle strobes the control path hands to the datapath
  typedef struct packed {
    logic sample;
    logic wrEn;
    logic ackEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_LVL = 6,
  parameter int LVL_W   = 3
) (
  input  logic                   sampleStb,
  input  logic                   regWrEn,
  input  logic                   ackValid,
  input  logic [LVL_W-1:0]       ackLevel,
  output irq_pkg::ctrlStrobes_t  strobes,
  output logic [NUM_LVL-1:0]     ackMask
);
  always_comb begin
    strobes.sample = sampleStb;
    strobes.wrEn   = regWrEn;
    strobes.ackEn  = ackValid;
  end

  // One-hot clear mask; codes at or above NUM_LVL match no bit
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_ack
    assign ackMask[i] = ackValid && (ackLevel == LVL_W'(i));
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath #(
  parameter int NUM_EXT     = 3,
  parameter int NUM_INT     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LVL    = NUM_EXT + NUM_INT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EXT-1:0]    extReq,
  input  logic [NUM_INT-1:0]    intReq,
  input  irq_pkg::ctrlStrobes_t strobes,
  input  logic [NUM_LVL-1:0]    ackMask,
  input  logic [NUM_LVL-1:0]    wrData,
  output logic [NUM_LVL-1:0]    firstStage,
  output logic [NUM_LVL-1:0]    reqReg
);
  logic [NUM_EXT-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LVL-1:0] curLvl, prevLvl, edgeHit, baseNext, reqNext;

  // Synchronizer chain for the external lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= extReq;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign curLvl  = {intReq, syncQ[SYNC_STAGES-1]};
  assign edgeHit = curLvl & ~prevLvl;

  // Edge history and first-stage catch; a new edge beats the sample clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl    <= '0;
      firstStage <= '0;
    end else begin
      prevLvl    <= curLvl;
      firstStage <= (firstStage & ~{NUM_LVL{strobes.sample}}) | edgeHit;
    end
  end

  // Second stage: write over acknowledge, then OR in sampled bits
  always_comb begin
    if (strobes.wrEn)       baseNext = wrData;
    else if (strobes.ackEn) baseNext = reqReg & ~ackMask;
    else                    baseNext = reqReg;
    reqNext = baseNext | (strobes.sample ? firstStage : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqReg <= '0;
    else       reqReg <= reqNext;
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_INT    = 3,
  localparam int NUM_LVL    = NUM_EXT + NUM_INT,
  localparam int LVL_W      = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic               rxDone,
  input  logic               t0End,
  input  logic               txEmpty,
  input  logic               lvl4SelTx,
  input  logic               t1End,
  input  logic               sampleStb,
  input  logic               ackValid,
  input  logic [LVL_W-1:0]   ackLevel,
  input  logic               regWrEn,
  input  logic [NUM_LVL-1:0] regWrData,
  output logic [NUM_LVL-1:0] reqReg
);
  irq_pkg::ctrlStrobes_t strobes;
  logic [NUM_LVL-1:0] ackMask;
  logic [NUM_LVL-1:0] firstStage;
  logic [NUM_INT-1:0] intReq;

  // Internal sources; the middle level picks one of two
  assign intReq = {t1End, (lvl4SelTx ? txEmpty : t0End), rxDone};

  irq_ctrl #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_ctrl (
    .sampleStb(sampleStb), .regWrEn(regWrEn), .ackValid(ackValid),
    .ackLevel(ackLevel), .strobes(strobes), .ackMask(ackMask)
  );

  irq_datapath #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extReq(extReq), .intReq(intReq),
    .strobes(strobes), .ackMask(ackMask), .wrData(regWrData),
    .firstStage(firstStage), .reqReg(reqReg)
  );
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
  parameter int NUM_LVL = 6,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               sampleStb,
  input logic               regWrEn,
  input logic [NUM_LVL-1:0] regWrData,
  input logic               ackValid,
  input logic [LVL_W-1:0]   ackLevel,
  input logic [NUM_LVL-1:0] firstStage,
  input logic [NUM_LVL-1:0] reqReg
);
  // R3
  catch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> ((firstStage & $past(firstStage)) == $past(firstStage)));

  // R6
  sample_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && !regWrEn && !ackValid) |=> (reqReg == ($past(reqReg) | $past(firstStage))));

  // R7
  ack_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !regWrEn && !sampleStb && (32'(ackLevel) < NUM_LVL))
      |=> (reqReg == ($past(reqReg) & ~(NUM_LVL'(1) << $past(ackLevel)))));

  // R8
  write_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (reqReg == ($past(regWrData) | ($past(sampleStb) ? $past(firstStage) : '0))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !regWrEn && !ackValid) |=> $stable(reqReg));
endmodule

bind irq_edge_latch irq_latch_chk #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .regWrEn(regWrEn),
  .regWrData(regWrData), .ackValid(ackValid), .ackLevel(ackLevel),
  .firstStage(firstStage), .reqReg(reqReg)
);

// File: tb/test_irq_edge_latch.sv
module test_irq_edge_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rstN = 0;
  logic [2:0] extReq = '0;
  logic rxDone = 0, t0End = 0, txEmpty = 0, lvl4SelTx = 0, t1End = 0;
  logic sampleStb = 0, ackValid = 0, regWrEn = 0;
  logic [2:0] ackLevel = '0;
  logic [5:0] regWrData = '0;
  logic [5:0] reqReg;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_edge_latch i_irq_edge_latch (
    .clk(clk), .rstN(rstN), .extReq(extReq), .rxDone(rxDone), .t0End(t0End),
    .txEmpty(txEmpty), .lvl4SelTx(lvl4SelTx), .t1End(t1End),
    .sampleStb(sampleStb), .ackValid(ackValid), .ackLevel(ackLevel),
    .regWrEn(regWrEn), .regWrData(regWrData), .reqReg(reqReg)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    total++;
    if (reqReg !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, reqReg, exp);
    end
  endtask

  task automatic writeReg(input logic [5:0] v);
    regWrEn = 1; regWrData = v; tick(); regWrEn = 0;
  endtask

  task automatic doSample();
    sampleStb = 1; tick(); sampleStb = 0;
  endtask

  // bit0 rxDone, bit1 t0End, bit2 txEmpty, bit3 t1End
  task automatic pulseInt(input logic [3:0] m);
    rxDone = m[0]; t0End = m[1]; txEmpty = m[2]; t1End = m[3];
    tick();
    rxDone = 0; t0End = 0; txEmpty = 0; t1End = 0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    check("R1", 6'h00);
    rstN = 1;
    tick();
    doSample();
    check("R1", 6'h00);

    // R2 / R3: sweep internal edge patterns
    for (int p = 0; p < 8; p++) begin
      writeReg(6'h00);
      pulseInt({p[2], 1'b0, p[1], p[0]});
      doSample();
      check("R2", 6'(p << 3));
      writeReg(6'h00);
      doSample();
      check("R3", 6'h00);
    end

    // R3: hold across many idle cycles
    pulseInt(4'b1000);
    repeat (5) tick();
    check("R3", 6'h00);
    doSample();
    check("R3", 6'h20);

    // R4: external latency sweep
    for (int p = 1; p < 8; p++) begin
      writeReg(6'h00);
      extReq = 3'(p);
      tick();
      tick();
      doSample();
      check("R4", 6'h00);
      doSample();
      check("R4", 6'(p));
      extReq = '0;
      repeat (4) tick();
    end

    // R5: level 4 source selection
    writeReg(6'h00);
    lvl4SelTx = 0;
    pulseInt(4'b0100); doSample(); check("R5", 6'h00);
    pulseInt(4'b0010); doSample(); check("R5", 6'h10);
    writeReg(6'h00);
    lvl4SelTx = 1;
    pulseInt(4'b0010); doSample(); check("R5", 6'h00);
    pulseInt(4'b0100); doSample(); check("R5", 6'h10);
    lvl4SelTx = 0;

    // R6 and R9
    writeReg(6'h01);
    pulseInt(4'b0001);
    doSample();
    check("R6", 6'h09);
    repeat (3) tick();
    check("R9", 6'h09);

    // R10: edge in the sample cycle survives
    writeReg(6'h00);
    rxDone = 1; tick(); rxDone = 0; tick();
    rxDone = 1; sampleStb = 1; tick();
    rxDone = 0; sampleStb = 0;
    check("R10", 6'h08);
    writeReg(6'h00);
    doSample();
    check("R10", 6'h08);

    // R8: write sweep
    for (int v = 0; v < 64; v++) begin
      writeReg(6'(v));
      check("R8", 6'(v));
    end

    // R7: acknowledge sweep
    for (int v = 0; v < 64; v += 3) begin
      for (int l = 0; l < 8; l++) begin
        writeReg(6'(v));
        ackValid = 1; ackLevel = 3'(l); tick(); ackValid = 0;
        check("R7", (l < 6) ? 6'(v & ~(1 << l)) : 6'(v));
      end
    end

    // R8: write beats ack, write ORed with sample
    writeReg(6'h3F);
    ackValid = 1; ackLevel = 3'd0; regWrEn = 1; regWrData = 6'h15; tick();
    ackValid = 0; regWrEn = 0;
    check("R8", 6'h15);
    pulseInt(4'b1000);
    regWrEn = 1; regWrData = 6'h01; sampleStb = 1; tick();
    regWrEn = 0; sampleStb = 0;
    check("R8", 6'h21);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule